// File: doc/BRIEF.md
# TMDS Colour Channel Encoder

This block turns one 8-bit colour component into a 10-bit line symbol for one lane of a transition-minimized differential video link. A full link uses three copies, one each for red, green and blue, next to a separate clock lane. On every pixel clock the block takes a data byte, a data-enable strobe and a 2-bit control code. It sends back one registered symbol. The serializer, the line driver and the decoder at the far end live outside this block.

Encoding runs in two steps. The first step chains the data bits with either XOR or XNOR, whichever gives fewer level changes inside the word, and records the choice in bit 8. The second step may invert the eight low bits so that the line has no net DC level, and records this in bit 9. The decision uses a signed running count of ones minus zeros. The count is cleared at reset and on every blanking cycle. During blanking the block sends one of four fixed control symbols.

Top module: `tmds_chan_enc`

## Requirements
- R1: While `rst_n` is low, `sym_out` is 10'b1101010100 and the running disparity is zero. The first data symbol after reset is therefore encoded as if the disparity were zero.
- R2: The output is registered. Inputs sampled at one rising clock edge show up on `sym_out` right after that same edge and hold for one pixel clock.
- R3: When `pix_de` is 0, `sym_out` is a control symbol chosen by `ctl_code`: 00 gives 10'b1101010100, 01 gives 10'b0010101011, 10 gives 10'b0101010100 and 11 gives 10'b1010101011.
- R4: The first stage sets q[0]=d[0]. For i=1..7 it uses q[i]=q[i-1] XNOR d[i] with bit 8 = 0 when the byte has more than four ones, or exactly four ones with d[0]=0. Otherwise it uses q[i]=q[i-1] XOR d[i] with bit 8 = 1. Bit 8 of the output always equals this flag.
- R5: If the running disparity is zero, or q[7:0] holds exactly four ones, then bit 9 is the inverse of bit 8. In that case bits 7:0 are q[7:0] when bit 8 is 1 and ~q[7:0] when bit 8 is 0.
- R6: In all other cases bit 9 is 1 and bits 7:0 are ~q[7:0] when the disparity and the ones-minus-zeros of q[7:0] have the same sign. Otherwise bit 9 is 0 and bits 7:0 are q[7:0].
- R7: After each data symbol the running disparity equals the total of (ones minus zeros) over all 10 bits of every data symbol sent since the last reset or blanking cycle. A blanking cycle sets it back to zero.
- R8: The running disparity never leaves the range -8 to +8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_de | input | 1 | 1 = active pixel data, 0 = blanking |
| pix_data | input | 8 | Colour component byte |
| ctl_code | input | 2 | Control code sent during blanking |
| sym_out | output | 10 | Encoded line symbol, registered |

## Verification
The hardest case to reach is the inversion branch with a disparity far from zero. It only occurs after several symbols in a row have pushed the imbalance the same way, and only when the next byte leans the same way as the current count. The stimulus reaches it with long runs of all-ones and all-zeros bytes, with a full sweep of the 256 byte values while the count drifts, and with a long pseudo-random stream that has blanking cycles mixed in. The count is therefore rebuilt from zero many times and both signs are hit at several magnitudes.

// File: rtl/tmds_enc_pkg.sv
package tmds_enc_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned SYM_W  = DATA_W + 2;
  localparam int unsigned CTL_W  = 2;
  localparam int unsigned CNT_W  = $clog2(DATA_W + 1);
  localparam int unsigned HALF   = DATA_W / 2;

  // population count of one data-width word
  function automatic logic [CNT_W-1:0] ones_of(input logic [DATA_W-1:0] v);
    logic [CNT_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < DATA_W; i++) acc = acc + CNT_W'(v[i]);
    return acc;
  endfunction

  // fixed blanking symbols
  function automatic logic [SYM_W-1:0] ctl_symbol(input logic [CTL_W-1:0] c);
    case (c)
      2'b00:   return 10'b1101010100;
      2'b01:   return 10'b0010101011;
      2'b10:   return 10'b0101010100;
      default: return 10'b1010101011;
    endcase
  endfunction
endpackage

// File: rtl/tmds_min_stage.sv
module tmds_min_stage
  import tmds_enc_pkg::*;
(
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W:0]   qm,
  output logic              use_xnor
);
  logic [CNT_W-1:0]  n_ones;
  logic [DATA_W-1:0] chain;

  assign n_ones   = ones_of(din);
  assign use_xnor = (n_ones > CNT_W'(HALF)) ||
                    ((n_ones == CNT_W'(HALF)) && !din[0]);

  always_comb begin
    chain[0] = din[0];
    for (int i = 1; i < DATA_W; i++) begin
      chain[i] = use_xnor ? ~(chain[i-1] ^ din[i]) : (chain[i-1] ^ din[i]);
    end
  end

  assign qm = {~use_xnor, chain};
endmodule

// File: rtl/tmds_balance_stage.sv
module tmds_balance_stage
  import tmds_enc_pkg::*;
#(
  parameter int DISP_W = 6
) (
  input  logic [DATA_W:0]           qm,
  input  logic signed [DISP_W-1:0]  disp_in,
  output logic [SYM_W-1:0]          sym,
  output logic signed [DISP_W-1:0]  disp_next
);
  localparam int PAD_W = DISP_W - CNT_W - 1;
  localparam logic signed [DISP_W-1:0] WORD_BIAS = DISP_W'(DATA_W);

  logic [CNT_W-1:0]         n_ones;
  logic signed [DISP_W-1:0] skew;      // ones minus zeros of qm low bits
  logic signed [DISP_W-1:0] flag_two;  // 2 when bit 8 set
  logic signed [DISP_W-1:0] nflag_two; // 2 when bit 8 clear
  logic                     neutral;
  logic                     same_sign;
  logic [DATA_W-1:0]        low;

  assign low       = qm[DATA_W-1:0];
  assign n_ones    = ones_of(low);
  assign skew      = $signed({{PAD_W{1'b0}}, n_ones, 1'b0}) - WORD_BIAS;
  assign flag_two  = $signed({{(DISP_W-2){1'b0}}, qm[DATA_W], 1'b0});
  assign nflag_two = $signed({{(DISP_W-2){1'b0}}, ~qm[DATA_W], 1'b0});
  assign neutral   = (disp_in == '0) || (skew == '0);
  assign same_sign = ((disp_in > 0) && (skew > 0)) ||
                     ((disp_in < 0) && (skew < 0));

  always_comb begin
    if (neutral) begin
      sym       = {~qm[DATA_W], qm[DATA_W], (qm[DATA_W] ? low : ~low)};
      disp_next = qm[DATA_W] ? (disp_in + skew) : (disp_in - skew);
    end else if (same_sign) begin
      sym       = {1'b1, qm[DATA_W], ~low};
      disp_next = disp_in + flag_two - skew;
    end else begin
      sym       = {1'b0, qm[DATA_W], low};
      disp_next = disp_in - nflag_two + skew;
    end
  end
endmodule

// File: rtl/tmds_chan_enc.sv
module tmds_chan_enc
  import tmds_enc_pkg::*;
#(
  parameter int DISP_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_de,
  input  logic [DATA_W-1:0] pix_data,
  input  logic [CTL_W-1:0]  ctl_code,
  output logic [SYM_W-1:0]  sym_out
);
  logic [DATA_W:0]          stage_qm;
  logic                     stage_xnor;
  logic [SYM_W-1:0]         enc_sym;
  logic signed [DISP_W-1:0] disp_q;
  logic signed [DISP_W-1:0] disp_d;

  tmds_min_stage u_min (
    .din      (pix_data),
    .qm       (stage_qm),
    .use_xnor (stage_xnor)
  );

  tmds_balance_stage #(.DISP_W(DISP_W)) u_bal (
    .qm        (stage_qm),
    .disp_in   (disp_q),
    .sym       (enc_sym),
    .disp_next (disp_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sym_out <= ctl_symbol('0);
      disp_q  <= '0;
    end else if (pix_de) begin
      sym_out <= enc_sym;
      disp_q  <= disp_d;
    end else begin
      sym_out <= ctl_symbol(ctl_code);
      disp_q  <= '0;
    end
  end
endmodule

// File: rtl/tmds_chan_enc_chk.sv
module tmds_chan_enc_chk
  import tmds_enc_pkg::*;
#(
  parameter int DISP_W = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     pix_de,
  input logic [DATA_W-1:0]        pix_data,
  input logic [CTL_W-1:0]         ctl_code,
  input logic [SYM_W-1:0]         sym_out,
  input logic [DATA_W:0]          stage_qm,
  input logic signed [DISP_W-1:0] disp_q
);
  function automatic int net10(input logic [SYM_W-1:0] s);
    int k;
    k = 0;
    for (int i = 0; i < SYM_W; i++) k += int'(s[i]);
    return 2 * k - SYM_W;
  endfunction

  function automatic int net8(input logic [DATA_W-1:0] s);
    int k;
    k = 0;
    for (int i = 0; i < DATA_W; i++) k += int'(s[i]);
    return 2 * k - DATA_W;
  endfunction

  a_r3_blank_symbol: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_de |=> sym_out == ctl_symbol($past(ctl_code)));

  a_r4_xnor_form: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_de && (net8(pix_data) > 0 || (net8(pix_data) == 0 && !pix_data[0])))
      |=> !sym_out[DATA_W]);

  a_r4_xor_form: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_de && (net8(pix_data) < 0 || (net8(pix_data) == 0 && pix_data[0])))
      |=> sym_out[DATA_W]);

  a_r5_neutral_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_de && disp_q == '0) |=> sym_out[SYM_W-1] != sym_out[DATA_W]);

  a_r6_invert_high: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_de && disp_q > 0 && net8(stage_qm[DATA_W-1:0]) > 0)
      |=> sym_out[SYM_W-1]);

  a_r7_disp_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    pix_de |=> int'(disp_q) == int'($past(disp_q)) + net10(sym_out));

  a_r7_blank_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_de |=> disp_q == '0);

  a_r8_disp_range: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_q <= 8) && (disp_q >= -8));
endmodule

bind tmds_chan_enc tmds_chan_enc_chk #(.DISP_W(DISP_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .pix_de   (pix_de),
  .pix_data (pix_data),
  .ctl_code (ctl_code),
  .sym_out  (sym_out),
  .stage_qm (stage_qm),
  .disp_q   (disp_q)
);

// File: tb/tmds_chan_enc_tb_top.sv
`timescale 1ns/1ps
module tmds_chan_enc_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_de = 1'b0;
  logic [7:0] pix_data = 8'h00;
  logic [1:0] ctl_code = 2'b00;
  logic [9:0] sym_out;

  int checks = 0;
  int failures = 0;
  int model_disp = 0;
  int mon_disp = 0;
  bit done = 1'b0;

  typedef struct {
    logic [9:0] sym;
    logic       de;
    string      req;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  tmds_chan_enc dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pix_de   (pix_de),
    .pix_data (pix_data),
    .ctl_code (ctl_code),
    .sym_out  (sym_out)
  );

  function automatic logic [9:0] ref_ctl(input logic [1:0] c);
    case (c)
      2'b00:   return 10'b1101010100;
      2'b01:   return 10'b0010101011;
      2'b10:   return 10'b0101010100;
      default: return 10'b1010101011;
    endcase
  endfunction

  // driver: applies one cycle of stimulus and queues the expected symbol
  task automatic drive(input logic de, input logic [7:0] d,
                       input logic [1:0] c, input string req);
    exp_t it;
    logic [8:0] qm;
    logic [9:0] s;
    logic x;
    int n;
    @(negedge clk);
    pix_de = de; pix_data = d; ctl_code = c;
    if (!de) begin
      s = ref_ctl(c);
      model_disp = 0;
    end else begin
      n = 0;
      for (int i = 0; i < 8; i++) n += int'(d[i]);
      x = (n > 4) || (n == 4 && d[0] == 1'b0);
      qm[0] = d[0];
      for (int i = 1; i < 8; i++) qm[i] = x ? (qm[i-1] == d[i]) : (qm[i-1] != d[i]);
      qm[8] = !x;
      n = 0;
      for (int i = 0; i < 8; i++) n += int'(qm[i]);
      if (model_disp == 0 || n == 4)
        s = {!qm[8], qm[8], (qm[8] ? qm[7:0] : ~qm[7:0])};
      else if ((model_disp > 0) == (n > 4))
        s = {1'b1, qm[8], ~qm[7:0]};
      else
        s = {1'b0, qm[8], qm[7:0]};
      n = 0;
      for (int i = 0; i < 10; i++) n += int'(s[i]);
      model_disp += 2 * n - 10;
    end
    it.sym = s; it.de = de; it.req = req;
    exp_q.push_back(it);
  endtask

  // monitor: one symbol per clock, sampled 1 ns after the edge (R2 latency)
  initial begin
    exp_t it;
    int n;
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        it = exp_q.pop_front();
        checks++;
        if (sym_out !== it.sym) begin
          failures++;
          $display("FAIL %s/R2 symbol actual=%b expected=%b", it.req, sym_out, it.sym);
        end
        if (it.de) begin
          n = 0;
          for (int i = 0; i < 10; i++) n += int'(sym_out[i]);
          mon_disp += 2 * n - 10;
          checks++;
          if (mon_disp > 8 || mon_disp < -8) begin
            failures++;
            $display("FAIL R8 running disparity actual=%0d expected=-8..8", mon_disp);
          end
        end else begin
          mon_disp = 0;
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (sym_out !== 10'b1101010100) begin
      failures++;
      $display("FAIL R1 reset symbol actual=%b expected=%b", sym_out, 10'b1101010100);
    end
    rst_n = 1'b1;

    // R1: first data symbol after reset uses zero disparity
    drive(1'b1, 8'h3C, 2'b00, "R1");
    // R3: all four control codes
    drive(1'b0, 8'hAA, 2'b00, "R3");
    drive(1'b0, 8'hAA, 2'b01, "R3");
    drive(1'b0, 8'h55, 2'b10, "R3");
    drive(1'b0, 8'h00, 2'b11, "R3");
    // R4: form selection corners
    drive(1'b1, 8'h0F, 2'b00, "R4");
    drive(1'b1, 8'hF0, 2'b00, "R4");
    drive(1'b1, 8'h00, 2'b00, "R4");
    drive(1'b1, 8'hFF, 2'b00, "R4");
    drive(1'b1, 8'h01, 2'b00, "R4");
    drive(1'b1, 8'h1F, 2'b00, "R4");
    // R5/R6: full byte sweep while disparity drifts
    for (int v = 0; v < 256; v++) drive(1'b1, 8'(v), 2'b00, "R6");
    drive(1'b0, 8'h00, 2'b01, "R7");
    for (int v = 0; v < 256; v++) drive(1'b1, 8'(v), 2'b00, "R5");
    // R8: long skewed runs
    for (int k = 0; k < 24; k++) drive(1'b1, 8'hFF, 2'b00, "R8");
    for (int k = 0; k < 24; k++) drive(1'b1, 8'h00, 2'b00, "R8");
    for (int k = 0; k < 24; k++) drive(1'b1, 8'hFE, 2'b00, "R8");
    for (int k = 0; k < 24; k++) drive(1'b1, 8'h01, 2'b00, "R8");
    // R7: blanking clears the running count mid-stream
    drive(1'b1, 8'hFF, 2'b00, "R7");
    drive(1'b1, 8'hFF, 2'b00, "R7");
    drive(1'b0, 8'h12, 2'b10, "R7");
    drive(1'b1, 8'hFF, 2'b00, "R7");
    drive(1'b1, 8'h10, 2'b00, "R7");
    // pseudo-random traffic with sparse blanking
    lfsr = 16'hACE1;
    for (int k = 0; k < 2000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive((lfsr[15:12] != 4'h0), lfsr[7:0], lfsr[9:8], "R7");
    end
    drive(1'b0, 8'h00, 2'b00, "R3");
    @(negedge clk);
    wait (exp_q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule